// File: doc/BRIEF.md
# Oversampled SPI Command Slave

This block is an SPI target that lives entirely in the system clock domain. The serial clock, data-in and chip-select lines pass through synchronizer chains. Edges of the serial clock are found by comparing successive synchronized samples. The host sends commands in bursts. A burst opens when chip-select falls and closes when it rises. The first byte of a burst names a target address, and each byte after it is payload for that address. The block does not interpret either one.

Each received byte appears on an 8-bit parallel output with a one-cycle valid pulse. A first flag marks the opening byte of a burst and a last flag marks the closing byte. To place the last flag correctly, every completed byte is held until the next byte completes or the burst closes, and only then is it emitted.

The path back to the host carries a single status byte. It is captured when the burst opens and is shifted out in the first byte slot. The block returns zeros in the second slot and in every later slot. The bus uses SPI mode 0 with MSB-first bit order. The serial clock must run at about a quarter of the system clock or slower.

Top module: `spi_cmd_slave`

## Requirements
- R1: After reset, rx_valid_o, rx_first_o, rx_last_o and miso_o are all 0.
- R2: Data-in is sampled on detected rising edges of the serial clock, MSB first. Eight samples make one byte on rx_data_o.
- R3: The first byte completed in a burst is emitted with rx_first_o=1. Every later byte in that burst is emitted with rx_first_o=0.
- R4: The final complete byte of a burst is emitted only after chip-select rises, with rx_last_o=1. Every earlier byte is emitted with rx_last_o=0, before the burst closes.
- R5: A burst that contains exactly one byte yields one strobe with both rx_first_o=1 and rx_last_o=1.
- R6: A partial byte of fewer than 8 bits that is pending when chip-select rises produces no strobe.
- R7: rx_valid_o is high for exactly one system clock cycle per byte.
- R8: status_i is captured when chip-select falls. It is returned MSB first on miso_o during the first byte slot, and later changes to status_i have no effect during that burst.
- R9: miso_o is 0 for all 8 bits of the second byte slot.
- R10: miso_o is 0 while chip-select is high.
- R11: The bit counter returns to zero while chip-select is high, so a new burst starts byte-aligned after a partial byte.
- R12: Serial clock and data-in activity while chip-select is high produces no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host (asynchronous) |
| mosi_i | input | 1 | Serial data from the host |
| csn_i | input | 1 | Active-low chip-select from the host |
| miso_o | output | 1 | Serial data to the host |
| status_i | input | 8 | Status byte to return to the host |
| rx_data_o | output | 8 | Received byte |
| rx_valid_o | output | 1 | One-cycle strobe: rx_data_o is valid |
| rx_first_o | output | 1 | Strobed byte is the first of its burst |
| rx_last_o | output | 1 | Strobed byte is the last of its burst |

## Verification
When a byte completes in the middle of a burst, two things happen in the same cycle: the held previous byte is emitted, and the new byte is loaded into the hold register. Multi-byte bursts provoke this on every byte boundary. The bench judges it by the order, values and flags of the captured strobes. The other point of contention is the closing edge of chip-select, which must flush the held byte while a partial byte is being discarded. A burst ending mid-byte exercises that case, and a following single-byte burst shows whether framing stayed aligned.

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              csn_i,
  output logic              miso_o,
  input  logic [BYTE_W-1:0] status_i,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  output logic              rx_first_o,
  output logic              rx_last_o
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic [SYNC_STAGES-1:0] sck_sync, mosi_sync, csn_sync;
  logic sck_q, csn_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sync  <= '0;
      mosi_sync <= '0;
      csn_sync  <= '1;
      sck_q     <= 1'b0;
      csn_q     <= 1'b1;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      csn_sync  <= {csn_sync[SYNC_STAGES-2:0], csn_i};
      sck_q     <= sck_sync[SYNC_STAGES-1];
      csn_q     <= csn_sync[SYNC_STAGES-1];
    end
  end

  logic sck_s, mosi_s, csn_s, cs_act;
  assign sck_s  = sck_sync[SYNC_STAGES-1];
  assign mosi_s = mosi_sync[SYNC_STAGES-1];
  assign csn_s  = csn_sync[SYNC_STAGES-1];
  assign cs_act = ~csn_s;

  logic sck_rise, sck_fall, cs_fall, cs_rise;
  assign sck_rise = cs_act & sck_s & ~sck_q;
  assign sck_fall = cs_act & ~sck_s & sck_q;
  assign cs_fall  = csn_q & ~csn_s;
  assign cs_rise  = ~csn_q & csn_s;

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] new_byte;
  logic              byte_done;

  assign new_byte  = {rx_sr[BYTE_W-2:0], mosi_s};
  assign byte_done = sck_rise & (bit_cnt == LAST_BIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      rx_sr   <= '0;
    end else if (csn_s) begin
      bit_cnt <= '0;
    end else if (sck_rise) begin
      bit_cnt <= bit_cnt + 1'b1;
      rx_sr   <= new_byte;
    end
  end

  logic [BYTE_W-1:0] hold_data;
  logic              hold_first, hold_vld, seen_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_data  <= '0;
      hold_first <= 1'b0;
      hold_vld   <= 1'b0;
      seen_byte  <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      rx_first_o <= 1'b0;
      rx_last_o  <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      rx_first_o <= 1'b0;
      rx_last_o  <= 1'b0;
      if (hold_vld && (cs_rise || byte_done)) begin
        rx_data_o  <= hold_data;
        rx_valid_o <= 1'b1;
        rx_first_o <= hold_first;
        rx_last_o  <= cs_rise;
      end
      if (cs_rise)
        hold_vld <= 1'b0;
      if (byte_done) begin
        hold_data  <= new_byte;
        hold_first <= ~seen_byte;
        hold_vld   <= 1'b1;
        seen_byte  <= 1'b1;
      end
      if (cs_fall) begin
        hold_vld  <= 1'b0;
        seen_byte <= 1'b0;
      end
    end
  end

  logic [BYTE_W-1:0] tx_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx_sr <= '0;
    else if (cs_fall)
      tx_sr <= status_i;
    else if (csn_s)
      tx_sr <= '0;
    else if (sck_fall)
      tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
  end

  assign miso_o = tx_sr[BYTE_W-1];
endmodule

// File: rtl/spi_cmd_slave_chk.sv
module spi_cmd_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       csn_s,
  input logic [2:0] bit_cnt,
  input logic       miso_o,
  input logic       rx_valid_o,
  input logic       rx_first_o,
  input logic       rx_last_o
);
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);

  assert_last_after_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && rx_last_o) |-> $past(csn_s));

  assert_mid_burst_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && !rx_last_o) |-> !$past(csn_s));

  assert_flags_need_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_first_o || rx_last_o) |-> rx_valid_o);

  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> !miso_o);

  assert_bitcnt_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    csn_s |=> (bit_cnt == 3'd0));
endmodule

bind spi_cmd_slave spi_cmd_slave_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .csn_s      (csn_s),
  .bit_cnt    (bit_cnt),
  .miso_o     (miso_o),
  .rx_valid_o (rx_valid_o),
  .rx_first_o (rx_first_o),
  .rx_last_o  (rx_last_o)
);

// File: tb/spi_cmd_slave_bench.sv
module spi_cmd_slave_bench;
  localparam int HP = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, mosi = 1'b0, csn = 1'b1;
  logic [7:0] status = '0;
  logic miso, rx_valid, rx_first, rx_last;
  logic [7:0] rx_data;

  always #5 clk = ~clk;

  spi_cmd_slave u_spi_cmd_slave (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .mosi_i(mosi), .csn_i(csn),
    .miso_o(miso), .status_i(status), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_first_o(rx_first), .rx_last_o(rx_last)
  );

  int tests = 0, fails = 0;
  logic [9:0] cap [0:31];
  int ncap = 0;
  logic prev_valid = 1'b0;
  int pulse_err = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (rx_valid) begin
      if (ncap < 32) cap[ncap] <= {rx_first, rx_last, rx_data};
      ncap <= ncap + 1;
      if (prev_valid) pulse_err <= pulse_err + 1;
    end
    prev_valid <= rx_valid;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic open_burst;
    csn = 1'b0;
    wait_clk(2 * HP);
  endtask

  task automatic close_burst;
    csn = 1'b1;
    wait_clk(3 * HP);
  endtask

  task automatic send_bits(input logic [7:0] b, input int nbits, output logic [7:0] got);
    got = '0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      mosi = b[i];
      wait_clk(HP);
      got[i] = miso;
      sck = 1'b1;
      wait_clk(HP);
      sck = 1'b0;
    end
  endtask

  task automatic test_reset;
    chk("R1 valid", rx_valid, 0);
    chk("R1 first", rx_first, 0);
    chk("R1 last", rx_last, 0);
    chk("R1 miso", miso, 0);
  endtask

  task automatic test_single;
    logic [7:0] got;
    int base = ncap;
    status = 8'hA5;
    open_burst();
    send_bits(8'h3C, 8, got);
    close_burst();
    chk("R8 status slot", got, 8'hA5);
    chk("R5 count", ncap - base, 1);
    chk("R5 flags+data R2", cap[base], {2'b11, 8'h3C});
  endtask

  task automatic test_multi;
    logic [7:0] got;
    logic [7:0] bytes [0:3];
    int base = ncap;
    bytes[0] = 8'h81; bytes[1] = 8'h7E; bytes[2] = 8'hC3; bytes[3] = 8'h01;
    status = 8'h5A;
    open_burst();
    status = 8'hFF;
    for (int k = 0; k < 4; k++) begin
      send_bits(bytes[k], 8, got);
      if (k == 0) chk("R8 captured at open", got, 8'h5A);
      if (k == 1) chk("R9 second slot", got, 8'h00);
      if (k == 2) chk("R4 not emitted early", ncap - base, 2);
    end
    chk("R4 held before close", ncap - base, 3);
    close_burst();
    chk("R2 count", ncap - base, 4);
    chk("R3 first byte", cap[base], {2'b10, 8'h81});
    chk("R3 mid byte", cap[base + 1], {2'b00, 8'h7E});
    chk("R3 mid byte 2", cap[base + 2], {2'b00, 8'hC3});
    chk("R4 last byte", cap[base + 3], {2'b01, 8'h01});
  endtask

  task automatic test_partial;
    logic [7:0] got;
    int base = ncap;
    open_burst();
    send_bits(8'h12, 8, got);
    send_bits(8'h34, 8, got);
    send_bits(8'hE0, 3, got);
    close_burst();
    chk("R6 count", ncap - base, 2);
    chk("R6 last flag moved", cap[base + 1], {2'b01, 8'h34});
    base = ncap;
    open_burst();
    send_bits(8'hF0, 8, got);
    close_burst();
    chk("R11 realign count", ncap - base, 1);
    chk("R11 realign data", cap[base], {2'b11, 8'hF0});
  endtask

  task automatic test_idle_sck;
    int base = ncap;
    int miso_hi = 0;
    for (int i = 0; i < 20; i++) begin
      mosi = i[0];
      sck = 1'b1;
      wait_clk(HP);
      if (miso) miso_hi++;
      sck = 1'b0;
      wait_clk(HP);
      if (miso) miso_hi++;
    end
    wait_clk(HP);
    chk("R12 no strobe", ncap - base, 0);
    chk("R10 miso idle", miso_hi, 0);
  endtask

  initial begin
    wait_clk(4);
    test_reset();
    rst_n = 1'b1;
    wait_clk(4);
    test_single();
    test_multi();
    test_partial();
    test_idle_sck();
    chk("R7 pulse width", pulse_err, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule